// File: doc/BRIEF.md
# Boot-Load Bus Glue

This block sits between a 16-bit-address-plus-bank CPU bus, a 512 KB static RAM and a small loader controller. The loader owns an 8-bit data port and two strobes: one writes a control register, the other writes a one-byte buffer. While the load-mode bit of the control register is set, the glue answers every CPU read with the buffered byte and sends every CPU write straight to RAM on a flat 19-bit address. The loader can therefore feed the processor one opcode or operand at a time and let it store bytes anywhere in RAM.

Once the load-mode bit is cleared, the glue decodes the normal system map. The top of bank 0 is a shadow ROM backed by RAM. Its upper part is folded into bank 4, and writes into it are refused unless the write-enable bit of the control register is 0. The other control bits are not used here. They are passed out unchanged for neighbouring logic.

Both strobes are sampled on the system clock, so a strobe level must last at least one clock cycle. Memory decode is combinational from the CPU bus and PHI2.

Top module: `boot_glue`

## Requirements
- R1: After reset, `ctl_bits` reads 0x80 (bit 7 load mode = 1, bit 5 write-enable = 0) and the byte buffer holds 0x00.
- R2: The control register takes `ld_data` only on a 0-to-1 transition of `ctl_stb`. Holding `ctl_stb` high or lowering it leaves the register unchanged.
- R3: The byte buffer takes `ld_data` only on a 0-to-1 transition of `buf_stb_n`, which idles high. The falling edge and the low phase have no effect.
- R4: When `ctl_bits[7]` is 1, a read (`cpu_rw`=1) with `phi2` high drives the byte buffer onto `cpu_dout` with `cpu_doe`=1, at any address, and keeps `ram_ce_n` high.
- R5: When `ctl_bits[7]` is 1, a write (`cpu_rw`=0) selects RAM at `cpu_addr[18:0]` for any bank, and ignores `ctl_bits[5]`.
- R6: When `ctl_bits[7]` is 0, banks 0 to 7 outside the shadow region and the I/O page map linearly to `cpu_addr[18:0]`. Banks 8 and above do not select RAM.
- R7: When `ctl_bits[7]` is 0, bank 0 addresses $C000 to $C0FF do not select RAM.
- R8: When `ctl_bits[7]` is 0, bank 0 $C100 to $CFFF maps to RAM bank 0 at the same offset. Bank 0 $D000 to $FFFF maps to RAM bank 4, that is `ram_addr` = {3'b100, addr[15:0]}.
- R9: When `ctl_bits[7]` is 0 and `ctl_bits[5]` is 1, a write to bank 0 $C100 to $FFFF keeps `ram_ce_n` and `ram_we_n` high. When `ctl_bits[5]` is 0, such a write reaches RAM.
- R10: `ram_we_n` goes low only while `phi2` is high and `cpu_rw` is 0. `cpu_doe` is 1 only while `phi2` is high, `cpu_rw` is 1 and `ctl_bits[7]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the loader strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_data | input | 8 | Loader data port |
| ctl_stb | input | 1 | Control register strobe, idles low |
| buf_stb_n | input | 1 | Byte buffer strobe, idles high |
| phi2 | input | 1 | CPU phase-2 clock |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_addr | input | 24 | CPU bank and address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_addr | output | 19 | RAM address |
| cpu_dout | output | 8 | Data driven to the CPU bus (byte buffer) |
| cpu_doe | output | 1 | Drive enable for `cpu_dout` |
| ctl_bits | output | 8 | Control register contents |

## Verification
The strobe properties assume that `ctl_stb` and `buf_stb_n` are steady across each clock edge and are low and high respectively while reset is released. The bench changes them only on falling clock edges and keeps them idle through reset. The decode properties assume that `cpu_addr`, `cpu_rw` and `phi2` are valid at each rising clock edge. The bench sets them on a falling edge and holds them for at least one full cycle before moving on.

// File: rtl/boot_glue.sv
module boot_glue #(
  parameter int DW        = 8,
  parameter int AW        = 24,
  parameter int RAW       = 19,
  parameter logic [15:0] IO_LO   = 16'hC000,
  parameter logic [15:0] IO_HI   = 16'hC0FF,
  parameter logic [15:0] ROM_LO  = 16'hC100,
  parameter logic [15:0] FOLD_LO = 16'hD000,
  parameter int NBANKS    = 8,
  parameter int FOLD_BANK = 4,
  parameter logic [DW-1:0] CTL_RST = 8'h80,
  parameter int LOAD_BIT  = 7,
  parameter int WE_BIT    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  ld_data,
  input  logic           ctl_stb,
  input  logic           buf_stb_n,
  input  logic           phi2,
  input  logic           cpu_rw,
  input  logic [AW-1:0]  cpu_addr,
  output logic           ram_ce_n,
  output logic           ram_we_n,
  output logic [RAW-1:0] ram_addr,
  output logic [DW-1:0]  cpu_dout,
  output logic           cpu_doe,
  output logic [DW-1:0]  ctl_bits
);
  localparam int BW  = AW - 16;
  localparam int HBW = RAW - 16;

  logic [DW-1:0] ctl_q, buf_q;
  logic          ctl_stb_q, buf_stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= CTL_RST;
      buf_q     <= '0;
      ctl_stb_q <= 1'b0;
      buf_stb_q <= 1'b1;
    end else begin
      ctl_stb_q <= ctl_stb;
      buf_stb_q <= buf_stb_n;
      if (ctl_stb && !ctl_stb_q)   ctl_q <= ld_data;
      if (buf_stb_n && !buf_stb_q) buf_q <= ld_data;
    end
  end

  wire [BW-1:0] bank = cpu_addr[AW-1:16];
  wire [15:0]   ofs  = cpu_addr[15:0];
  wire          load = ctl_q[LOAD_BIT];
  wire          b0   = (bank == '0);
  wire          io   = b0 && ofs >= IO_LO && ofs <= IO_HI;
  wire          rom  = b0 && ofs >= ROM_LO;
  wire          fold = b0 && ofs >= FOLD_LO;
  wire          inr  = (bank < BW'(NBANKS));
  wire          blk  = rom && ctl_q[WE_BIT] && !cpu_rw;
  wire          sel  = load ? !cpu_rw : (inr && !io && !blk);

  assign ram_ce_n = !sel;
  assign ram_we_n = !(sel && phi2 && !cpu_rw);
  assign ram_addr = (!load && fold) ? {HBW'(FOLD_BANK), ofs} : cpu_addr[RAW-1:0];
  assign cpu_doe  = load && phi2 && cpu_rw;
  assign cpu_dout = buf_q;
  assign ctl_bits = ctl_q;
endmodule

// File: rtl/boot_glue_chk.sv
module boot_glue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_stb,
  input logic        buf_stb_n,
  input logic        phi2,
  input logic        cpu_rw,
  input logic [23:0] cpu_addr,
  input logic        ram_ce_n,
  input logic        ram_we_n,
  input logic [7:0]  cpu_dout,
  input logic        cpu_doe,
  input logic [7:0]  ctl_bits
);
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$rose(ctl_stb)) |=> $stable(ctl_bits));

  assert_buf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$rose(buf_stb_n)) |=> $stable(cpu_dout));

  assert_load_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[7] && phi2 && cpu_rw) |-> (cpu_doe && ram_ce_n));

  assert_io_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_bits[7] && cpu_addr[23:8] == 16'h00C0) |-> ram_ce_n);

  assert_rom_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_bits[7] && ctl_bits[5] && !cpu_rw && cpu_addr[23:16] == 8'h00
     && cpu_addr[15:0] >= 16'hC100) |-> (ram_we_n && ram_ce_n));

  assert_we_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (phi2 && !cpu_rw));

  assert_doe_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_doe |-> (phi2 && cpu_rw && ctl_bits[7]));
endmodule

bind boot_glue boot_glue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_stb(ctl_stb), .buf_stb_n(buf_stb_n),
  .phi2(phi2), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .ram_ce_n(ram_ce_n),
  .ram_we_n(ram_we_n), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
  .ctl_bits(ctl_bits)
);

// File: tb/boot_glue_bench.sv
module boot_glue_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ld_data = 8'h00;
  logic        ctl_stb = 1'b0;
  logic        buf_stb_n = 1'b1;
  logic        phi2 = 1'b0;
  logic        cpu_rw = 1'b1;
  logic [23:0] cpu_addr = 24'h0;
  logic        ram_ce_n, ram_we_n, cpu_doe;
  logic [18:0] ram_addr;
  logic [7:0]  cpu_dout, ctl_bits;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_glue u_boot_glue (
    .clk(clk), .rst_n(rst_n), .ld_data(ld_data), .ctl_stb(ctl_stb),
    .buf_stb_n(buf_stb_n), .phi2(phi2), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_addr(ram_addr),
    .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .ctl_bits(ctl_bits)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic p, input logic rw, input logic [23:0] a);
    @(negedge clk);
    phi2 = p; cpu_rw = rw; cpu_addr = a;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ld_data = v; ctl_stb = 1'b1;
    @(negedge clk); ctl_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_buf(input logic [7:0] v);
    @(negedge clk); ld_data = v; buf_stb_n = 1'b0;
    @(negedge clk); buf_stb_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "ctl after reset", ctl_bits, 8'h80);
    bus(1'b1, 1'b1, 24'h00FFFC);
    chk("R1", "buffer after reset", cpu_dout, 8'h00);
    chk("R1", "doe in load read", cpu_doe, 1);
  endtask

  task automatic t_ctl_strobe;
    @(negedge clk); ld_data = 8'hA1; ctl_stb = 1'b1;
    @(negedge clk); #1;
    chk("R2", "ctl on rising strobe", ctl_bits, 8'hA1);
    ld_data = 8'h5E;
    repeat (3) @(negedge clk);
    #1 chk("R2", "ctl while strobe held", ctl_bits, 8'hA1);
    ctl_stb = 1'b0;
    repeat (2) @(negedge clk);
    #1 chk("R2", "ctl after strobe fall", ctl_bits, 8'hA1);
    write_ctl(8'h80);
    #1 chk("R2", "ctl back to load", ctl_bits, 8'h80);
  endtask

  task automatic t_buf_strobe;
    @(negedge clk); ld_data = 8'h3C; buf_stb_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R3", "buffer during low phase", cpu_dout, 8'h00);
    buf_stb_n = 1'b1;
    @(negedge clk); #1;
    chk("R3", "buffer on rising strobe", cpu_dout, 8'h3C);
    ld_data = 8'h99;
    repeat (2) @(negedge clk);
    #1 chk("R3", "buffer while idle high", cpu_dout, 8'h3C);
  endtask

  task automatic t_load_read;
    logic [23:0] addrs [4] = '{24'h000000, 24'h00C050, 24'h04E123, 24'hFF8001};
    write_buf(8'hEA);
    foreach (addrs[i]) begin
      bus(1'b1, 1'b1, addrs[i]);
      chk("R4", "load read doe", cpu_doe, 1);
      chk("R4", "load read data", cpu_dout, 8'hEA);
      chk("R4", "load read ram off", ram_ce_n, 1);
    end
    bus(1'b0, 1'b1, 24'h001000);
    chk("R10", "doe with phi2 low", cpu_doe, 0);
  endtask

  task automatic t_load_write;
    logic [23:0] addrs [4] = '{24'h7ABCDE, 24'h00C080, 24'h00E000, 24'h9A0011};
    write_ctl(8'hA0);
    foreach (addrs[i]) begin
      bus(1'b1, 1'b0, addrs[i]);
      chk("R5", "load write ce", ram_ce_n, 0);
      chk("R5", "load write we", ram_we_n, 0);
      chk("R5", "load write addr", ram_addr, int'(addrs[i][18:0]));
      chk("R10", "no drive on write", cpu_doe, 0);
    end
    bus(1'b0, 1'b0, 24'h012345);
    chk("R10", "we with phi2 low", ram_we_n, 1);
  endtask

  task automatic t_normal_map;
    write_ctl(8'h20);
    bus(1'b1, 1'b1, 24'h001234);
    chk("R6", "bank0 low ce", ram_ce_n, 0);
    chk("R6", "bank0 low addr", ram_addr, 19'h01234);
    chk("R10", "no drive in normal", cpu_doe, 0);
    bus(1'b1, 1'b1, 24'h03ABCD);
    chk("R6", "bank3 addr", ram_addr, 19'h3ABCD);
    bus(1'b1, 1'b1, 24'h07FFFF);
    chk("R6", "bank7 ce", ram_ce_n, 0);
    bus(1'b1, 1'b1, 24'h080000);
    chk("R6", "bank8 ce", ram_ce_n, 1);
    bus(1'b1, 1'b1, 24'h04D000);
    chk("R6", "bank4 direct addr", ram_addr, 19'h4D000);
    bus(1'b1, 1'b1, 24'h00C000);
    chk("R7", "io low ce", ram_ce_n, 1);
    bus(1'b1, 1'b1, 24'h00C0FF);
    chk("R7", "io high ce", ram_ce_n, 1);
    bus(1'b1, 1'b1, 24'h00C100);
    chk("R8", "rom low ce", ram_ce_n, 0);
    chk("R8", "rom low addr", ram_addr, 19'h0C100);
    bus(1'b1, 1'b1, 24'h00CFFF);
    chk("R8", "rom bank0 top", ram_addr, 19'h0CFFF);
    bus(1'b1, 1'b1, 24'h00D000);
    chk("R8", "fold low", ram_addr, 19'h4D000);
    bus(1'b1, 1'b1, 24'h00FFFC);
    chk("R8", "fold vector", ram_addr, 19'h4FFFC);
  endtask

  task automatic t_protect;
    bus(1'b1, 1'b0, 24'h00D123);
    chk("R9", "locked fold we", ram_we_n, 1);
    chk("R9", "locked fold ce", ram_ce_n, 1);
    bus(1'b1, 1'b0, 24'h00C100);
    chk("R9", "locked rom we", ram_we_n, 1);
    bus(1'b1, 1'b0, 24'h001000);
    chk("R9", "plain ram write", ram_we_n, 0);
    write_ctl(8'h00);
    bus(1'b1, 1'b0, 24'h00D123);
    chk("R9", "open fold we", ram_we_n, 0);
    chk("R9", "open fold addr", ram_addr, 19'h4D123);
    bus(1'b0, 1'b0, 24'h00D123);
    chk("R10", "open fold phi2 low", ram_we_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctl_strobe();
    t_buf_strobe();
    t_load_read();
    t_load_write();
    t_normal_map();
    t_protect();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule